// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits in the decode stage of a five-stage in-order pipeline that forwards results from its later stages. Forwarding cannot serve a load whose result is wanted by the very next instruction, because the loaded word exists only after the memory stage. The detector finds that one case and stalls for it. It compares the destination register of a load sitting in execute with both source register fields of the instruction in decode.

On a match the detector drops the write enables of the program counter and of the fetch/decode pipeline register, so that fetch and decode both hold their instructions. In the same cycle it clears every control field on its way into the decode/execute register, so that an empty slot travels down the pipeline and changes no state.

On the next cycle the load has moved on to memory. The execute slot then holds the cleared slot, whose memory-read field is zero, so the stall ends by itself after exactly one cycle. The loaded value is then supplied to the consumer by the forwarding path, which lies outside this block. The detector is purely combinational.

Top module: `loaduse_stall_unit`

## Requirements
- R1: When `ex_mem_rd` is 1, `ex_rt` is nonzero and `ex_rt` equals `dec_rs`, a stall is raised (`pc_wr_en`=0, `ifid_wr_en`=0, `bubble_sel`=1).
- R2: When `ex_mem_rd` is 1, `ex_rt` is nonzero and `ex_rt` equals `dec_rt`, a stall is raised, whatever the value of `dec_rs`.
- R3: When `ex_mem_rd` is 0, no stall is raised for any register values.
- R4: A load whose destination `ex_rt` is register 0 never raises a stall, even when a source field in decode is also 0.
- R5: `pc_wr_en` is 0 exactly in the cycles where a stall is raised and 1 otherwise.
- R6: `ifid_wr_en` is 0 exactly in the cycles where a stall is raised and 1 otherwise, always equal to `pc_wr_en`.
- R7: While `bubble_sel` is 1, `idex_ctrl_o` is all zero. Otherwise it equals `dec_ctrl`. Bit order, MSB first: reg-write[8], mem-to-reg[7], mem-read[6], mem-write[5], branch[4], ALU op[3:2], ALU source[1], register destination[0].
- R8: In a pipeline, a load followed at once by an instruction that reads its destination costs exactly one stall cycle. A chain of two such dependent pairs costs two stall cycles.
- R9: In a pipeline, a load followed by an unrelated instruction and then a consumer of the loaded register costs no stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_rd | input | 1 | Memory-read control of the instruction now in execute |
| ex_rt | input | REG_AW | Destination register field of the instruction in execute |
| dec_rs | input | REG_AW | First source register field of the instruction in decode |
| dec_rt | input | REG_AW | Second source register field of the instruction in decode |
| dec_ctrl | input | 9 | Control fields decoded for the instruction in decode |
| pc_wr_en | output | 1 | Program counter write enable, low during a stall |
| ifid_wr_en | output | 1 | Fetch/decode register write enable, low during a stall |
| bubble_sel | output | 1 | High when the control fields entering execute are cleared |
| idex_ctrl_o | output | 9 | Control fields to load into the decode/execute register |

## Verification
Every combination of the memory-read flag and the three register fields at the default width is applied. This separates a hit on the first source from a hit on the second, a hit on both, a register-0 destination that matches, and a match with no load present. The control bundle changes with each combination, so a pass-through that ignores the select, or clears only some fields, shows up as a mismatch. Short instruction sequences are then run through a small pipeline model in the bench, which counts stall cycles:
- an adjacent load-use pair, with the hit on either source field;
- a load, an unrelated instruction, then a use;
- a register-0 load;
- two chained load-use pairs.

These runs tell a single-cycle stall apart from a stall that repeats or never ends.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef struct packed {
    logic       reg_wr;
    logic       mem_to_reg;
    logic       mem_rd;
    logic       mem_wr;
    logic       branch;
    logic [1:0] alu_op;
    logic       alu_src;
    logic       reg_dst;
  } idex_ctrl_t;

  localparam int HZ_CTRL_W = $bits(idex_ctrl_t);
  localparam int HZ_NUM_SRC = 2;

endpackage

// File: rtl/hzd_reg_match.sv
module hzd_reg_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_reg,
  input  logic [REG_AW-1:0] load_dst,
  output logic              hit
);

  logic dst_nonzero;
  logic same_reg;

  always_comb begin
    dst_nonzero = |load_dst;
    same_reg    = (src_reg == load_dst);
    hit         = dst_nonzero & same_reg;
  end

endmodule

// File: rtl/hzd_bubble_mux.sv
module hzd_bubble_mux #(
  parameter int WIDTH = 9
) (
  input  logic             kill,
  input  logic [WIDTH-1:0] ctrl_in,
  output logic [WIDTH-1:0] ctrl_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign ctrl_out[b] = ctrl_in[b] & ~kill;
  end

endmodule

// File: rtl/loaduse_stall_unit.sv
module loaduse_stall_unit
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic                 ex_mem_rd,
  input  logic [REG_AW-1:0]    ex_rt,
  input  logic [REG_AW-1:0]    dec_rs,
  input  logic [REG_AW-1:0]    dec_rt,
  input  logic [HZ_CTRL_W-1:0] dec_ctrl,
  output logic                 pc_wr_en,
  output logic                 ifid_wr_en,
  output logic                 bubble_sel,
  output logic [HZ_CTRL_W-1:0] idex_ctrl_o
);

  logic [REG_AW-1:0]     src_regs [HZ_NUM_SRC];
  logic [HZ_NUM_SRC-1:0] src_hit;
  logic                  stall;

  always_comb begin
    src_regs[0] = dec_rs;
    src_regs[1] = dec_rt;
  end

  for (genvar s = 0; s < HZ_NUM_SRC; s++) begin : g_src
    hzd_reg_match #(.REG_AW(REG_AW)) u_match (
      .src_reg  (src_regs[s]),
      .load_dst (ex_rt),
      .hit      (src_hit[s])
    );
  end

  always_comb begin
    stall      = ex_mem_rd & (|src_hit);
    pc_wr_en   = ~stall;
    ifid_wr_en = ~stall;
    bubble_sel = stall;
  end

  hzd_bubble_mux #(.WIDTH(HZ_CTRL_W)) u_bubble (
    .kill     (bubble_sel),
    .ctrl_in  (dec_ctrl),
    .ctrl_out (idex_ctrl_o)
  );

endmodule

// File: rtl/loaduse_stall_chk.sv
module loaduse_stall_chk
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input logic                 ex_mem_rd,
  input logic [REG_AW-1:0]    ex_rt,
  input logic [REG_AW-1:0]    dec_rs,
  input logic [REG_AW-1:0]    dec_rt,
  input logic [HZ_CTRL_W-1:0] dec_ctrl,
  input logic                 pc_wr_en,
  input logic                 ifid_wr_en,
  input logic                 bubble_sel,
  input logic [HZ_CTRL_W-1:0] idex_ctrl_o
);

  logic known;

  always_comb begin
    known = !$isunknown({ex_mem_rd, ex_rt, dec_rs, dec_rt, dec_ctrl,
                         pc_wr_en, ifid_wr_en, bubble_sel, idex_ctrl_o});
    if (known) begin
      AST_HIT_RS_STALLS: assert (!(ex_mem_rd && ex_rt != '0 && ex_rt == dec_rs) || !pc_wr_en); // R1
      AST_HIT_RT_STALLS: assert (!(ex_mem_rd && ex_rt != '0 && ex_rt == dec_rt) || !pc_wr_en); // R2
      AST_NO_LOAD_NO_STALL: assert (ex_mem_rd || pc_wr_en); // R3
      AST_ZERO_DST_NO_STALL: assert (ex_rt != '0 || pc_wr_en); // R4
      AST_PC_FOLLOWS_BUBBLE: assert (pc_wr_en == !bubble_sel); // R5
      AST_IFID_MATCHES_PC: assert (ifid_wr_en == pc_wr_en); // R6
      AST_BUBBLE_CLEARS_CTRL: assert (!bubble_sel || idex_ctrl_o == '0); // R7
      AST_CTRL_PASSES: assert (bubble_sel || idex_ctrl_o == dec_ctrl); // R7
    end
  end

endmodule

bind loaduse_stall_unit loaduse_stall_chk #(.REG_AW(REG_AW)) u_chk (
  .ex_mem_rd   (ex_mem_rd),
  .ex_rt       (ex_rt),
  .dec_rs      (dec_rs),
  .dec_rt      (dec_rt),
  .dec_ctrl    (dec_ctrl),
  .pc_wr_en    (pc_wr_en),
  .ifid_wr_en  (ifid_wr_en),
  .bubble_sel  (bubble_sel),
  .idex_ctrl_o (idex_ctrl_o)
);

// File: tb/tb_loaduse_stall_unit.sv
module tb_loaduse_stall_unit;
  import hzd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int REG_AW     = 5;
  localparam int NREG       = 1 << REG_AW;
  localparam int WD_CYCLES  = 150000;

  logic clk;
  logic rst_n;
  logic                 ex_mem_rd;
  logic [REG_AW-1:0]    ex_rt, dec_rs, dec_rt;
  logic [HZ_CTRL_W-1:0] dec_ctrl;
  logic                 pc_wr_en, ifid_wr_en, bubble_sel;
  logic [HZ_CTRL_W-1:0] idex_ctrl_o;

  int n_checks;
  int n_fails;
  bit done;

  loaduse_stall_unit #(.REG_AW(REG_AW)) dut (
    .ex_mem_rd   (ex_mem_rd),
    .ex_rt       (ex_rt),
    .dec_rs      (dec_rs),
    .dec_rt      (dec_rt),
    .dec_ctrl    (dec_ctrl),
    .pc_wr_en    (pc_wr_en),
    .ifid_wr_en  (ifid_wr_en),
    .bubble_sel  (bubble_sel),
    .idex_ctrl_o (idex_ctrl_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  // Program record for the pipeline model
  typedef struct {
    bit       is_ld;
    bit [4:0] rs;
    bit [4:0] rt;
  } instr_t;

  instr_t prog [8];

  // Runs n instructions through a bench pipeline model and counts stall cycles
  task automatic run_prog(input int n, input int exp_stalls, input string req);
    int       pc = 0;
    bit       ifid_v = 0;
    int       ifid_i = 0;
    bit       idex_rd = 0;
    bit [4:0] idex_rt = 0;
    int       stalls = 0;
    idex_ctrl_t c;
    idex_ctrl_t co;
    for (int cyc = 0; cyc < n + 6; cyc++) begin
      @(posedge clk);
      c = '0;
      c.reg_wr  = 1'b1;
      c.alu_src = 1'b1;
      if (ifid_v) c.mem_rd = prog[ifid_i].is_ld;
      ex_mem_rd = idex_rd;
      ex_rt     = idex_rt;
      dec_rs    = ifid_v ? prog[ifid_i].rs : '0;
      dec_rt    = ifid_v ? prog[ifid_i].rt : '0;
      dec_ctrl  = c;
      @(negedge clk);
      if (!pc_wr_en) stalls++;
      co      = idex_ctrl_o;
      idex_rd = co.mem_rd;
      idex_rt = ifid_v ? prog[ifid_i].rt : '0;
      if (ifid_wr_en) begin
        if (pc < n) begin
          ifid_v = 1'b1;
          ifid_i = pc;
          pc++;
        end else begin
          ifid_v = 1'b0;
        end
      end
    end
    check(req, stalls, exp_stalls);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    ex_mem_rd = 1'b0;
    ex_rt = '0; dec_rs = '0; dec_rt = '0; dec_ctrl = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Quiet state: no load in execute, no stall (R3, R5, R6)
    @(negedge clk);
    check("R3 idle", {31'd0, pc_wr_en}, 32'd1);
    check("R6 idle", {31'd0, ifid_wr_en}, 32'd1);

    // Exhaustive sweep over flag and three register fields
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < NREG; t++) begin
        for (int s = 0; s < NREG; s++) begin
          for (int u = 0; u < NREG; u++) begin
            bit exp_st;
            logic [HZ_CTRL_W-1:0] pat;
            string tag;
            @(posedge clk);
            pat = HZ_CTRL_W'((t * 37 + s * 11 + u * 5 + m * 3 + 1) % (1 << HZ_CTRL_W));
            ex_mem_rd = m[0];
            ex_rt     = t[REG_AW-1:0];
            dec_rs    = s[REG_AW-1:0];
            dec_rt    = u[REG_AW-1:0];
            dec_ctrl  = pat;
            exp_st = (m == 1) && (t != 0) && ((t == s) || (t == u));
            if (m == 0) tag = "R3";
            else if (t == 0) tag = "R4";
            else if (t == s) tag = "R1";
            else if (t == u) tag = "R2";
            else tag = "R1/R2 miss";
            @(negedge clk);
            check({tag, " R5 pc_wr_en"}, {31'd0, pc_wr_en}, {31'd0, !exp_st});
            check({tag, " R6 ifid_wr_en"}, {31'd0, ifid_wr_en}, {31'd0, !exp_st});
            check({tag, " bubble_sel"}, {31'd0, bubble_sel}, {31'd0, exp_st});
            check("R7 ctrl", {23'd0, idex_ctrl_o}, exp_st ? 32'd0 : {23'd0, pat});
          end
        end
      end
    end

    // R8: load r2 then add reading r2 on rs -> one stall
    prog[0] = '{1, 5'd1, 5'd2};
    prog[1] = '{0, 5'd2, 5'd4};
    run_prog(2, 1, "R8 load-use on rs");

    // R8: load r5 then store reading r5 on rt -> one stall (R2 path)
    prog[0] = '{1, 5'd1, 5'd5};
    prog[1] = '{0, 5'd1, 5'd5};
    run_prog(2, 1, "R8 load-use on rt");

    // R8: chained pairs, lw r2; lw r3 via r2; add r3 -> two stalls
    prog[0] = '{1, 5'd1, 5'd2};
    prog[1] = '{1, 5'd2, 5'd3};
    prog[2] = '{0, 5'd3, 5'd3};
    run_prog(3, 2, "R8 chained");

    // R9: load r2, unrelated, consumer of r2 -> no stall
    prog[0] = '{1, 5'd1, 5'd2};
    prog[1] = '{0, 5'd6, 5'd7};
    prog[2] = '{0, 5'd2, 5'd2};
    run_prog(3, 0, "R9 gap of one");

    // R4: load to r0, then reader of r0 -> no stall
    prog[0] = '{1, 5'd1, 5'd0};
    prog[1] = '{0, 5'd0, 5'd0};
    run_prog(2, 0, "R4 r0 load");

    finish_run();
  end

endmodule